// File: doc/BRIEF.md
# Change-of-state interrupt controller

This block is a register-mapped digital input unit. It samples 32 asynchronous input lines through a synchronizer and lets a host read their present levels over a simple 32-bit register bus. The lower 16 lines can also raise an interrupt when their state changes.

Two 32-bit select masks choose which lines take part in interrupt generation and what each one waits for. A control register sets the combining mode and enables the interrupt.

In edge mode the interrupt fires as soon as any selected line makes its chosen transition. In level mode the interrupt fires only when every selected line sits at its chosen level at the same time. After a level-mode interrupt, the logic stays locked until some selected line changes level. Each accepted event captures the 16 interruptible line states. A read of the status register returns that snapshot and clears the pending event.

The bus is a single-cycle interface. Write data is taken on the clock edge where `bus_wr` is high. Read data is combinational from the address. A read of the status register acts on the clock edge where `bus_rd` is high.

Top module: `cos_irq_unit`

## Requirements
- R1: A read at byte address 0x00 returns the synchronized level of all 32 inputs, bit n holding input n.
- R2: The rise-select mask (address 0x04) and the fall-select mask (address 0x08) read back as written, in all 32 bits. The control register (address 0x10) reads back bits 1 and 2 as written, and all its other bits read 0.
- R3: With control bit 2 = 1 and control bit 1 = 0 (edge mode), a rise-mask bit set for channel c makes a 0→1 change on input c raise `irq_o`. A fall-mask bit set for channel c makes a 1→0 change on input c raise `irq_o`. A change in the opposite direction on that channel does not.
- R4: Mask bits 16..31, and changes on channels that are not selected, never cause an interrupt.
- R5: With control bit 2 = 1 and control bit 1 = 1 (level mode), an interrupt is raised only when every channel with a rise-mask bit set is high and every channel with a fall-mask bit set is low.
- R6: After a level-mode interrupt, no further interrupt occurs while the inputs stay steady. A level change on a selected channel re-arms the logic, so a later match fires again.
- R7: A read at address 0x0C returns, in bits 15..0, the input states of channels 0..15 captured with the accepted event, and clears the pending interrupt.
- R8: `irq_o` is the pending event gated by control bit 2. Clearing bit 2 drops `irq_o` but keeps the event. Setting bit 2 again re-asserts `irq_o` while the event is unread.
- R9: A further qualifying event while one is pending leaves the captured snapshot unchanged.
- R10: While control bit 2 is 0, input changes create no pending event.
- R11: After reset, the masks and control read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read side effect happens on the clock edge) |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| din | input | 32 | Asynchronous input lines |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Edge polarity is swept over every interruptible channel in both directions.

- A design that swaps the two masks, or that reacts to any toggle, raises `irq_o` on the wrong edge.
- A design that decodes mask bits above 15 fires on upper-line toggles.

All eight level combinations of a three-channel selection are tried. A design that ORs instead of ANDs fires on partial matches, and a design without the level lock fires again after the status read.

The bench also covers the following:
- Gating the enable off and on, where a design that clears the pending event loses the re-asserted request.
- A second event while one is pending, where a design that overwrites the snapshot returns the newer state.

// File: rtl/cos_pkg.sv
package cos_pkg;

  localparam int unsigned BUS_AW = 5;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] ADR_RAW    = 5'h00;
  localparam logic [BUS_AW-1:0] ADR_RISE   = 5'h04;
  localparam logic [BUS_AW-1:0] ADR_FALL   = 5'h08;
  localparam logic [BUS_AW-1:0] ADR_STATUS = 5'h0C;
  localparam logic [BUS_AW-1:0] ADR_CTRL   = 5'h10;

  localparam int unsigned CTRL_MODE_BIT = 1;
  localparam int unsigned CTRL_EN_BIT   = 2;

  typedef enum logic {
    CMB_ANY = 1'b0,
    CMB_ALL = 1'b1
  } combine_e;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[k] <= '0;
          else        stage_q[k] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[k] <= '0;
          else        stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int unsigned DW     = BUS_DW,
  parameter int unsigned AW     = BUS_AW,
  parameter int unsigned SNAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     raw_i,
  input  logic [SNAP_W-1:0] snap_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     rise_mask_o,
  output logic [DW-1:0]     fall_mask_o,
  output combine_e          mode_o,
  output logic              en_o,
  output logic              stat_rd_o
);

  logic [DW-1:0] rise_q, rise_d;
  logic [DW-1:0] fall_q, fall_d;
  combine_e      mode_q, mode_d;
  logic          en_q, en_d;
  logic          wr_rise, wr_fall, wr_ctrl;

  assign wr_rise = wr_i && (addr_i == ADR_RISE);
  assign wr_fall = wr_i && (addr_i == ADR_FALL);
  assign wr_ctrl = wr_i && (addr_i == ADR_CTRL);

  always_comb begin
    rise_d = rise_q;
    fall_d = fall_q;
    mode_d = mode_q;
    en_d   = en_q;
    if (wr_rise) rise_d = wdata_i;
    if (wr_fall) fall_d = wdata_i;
    if (wr_ctrl) begin
      mode_d = combine_e'(wdata_i[CTRL_MODE_BIT]);
      en_d   = wdata_i[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      mode_q <= CMB_ANY;
      en_q   <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_RAW:    rdata_o = raw_i;
      ADR_RISE:   rdata_o = rise_q;
      ADR_FALL:   rdata_o = fall_q;
      ADR_STATUS: rdata_o[SNAP_W-1:0] = snap_i;
      ADR_CTRL: begin
        rdata_o[CTRL_MODE_BIT] = mode_q;
        rdata_o[CTRL_EN_BIT]   = en_q;
      end
      default:    rdata_o = '0;
    endcase
  end

  assign rise_mask_o = rise_q;
  assign fall_mask_o = fall_q;
  assign mode_o      = mode_q;
  assign en_o        = en_q;
  assign stat_rd_o   = rd_i && (addr_i == ADR_STATUS);

endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] cur_i,
  input  logic [CH-1:0] prev_i,
  input  logic [CH-1:0] rise_mask_i,
  input  logic [CH-1:0] fall_mask_i,
  input  combine_e      mode_i,
  input  logic          en_i,
  output logic          evt_o
);

  logic [CH-1:0] sel;
  logic [CH-1:0] edge_hit;
  logic [CH-1:0] lvl_ok;
  logic          edge_evt, lvl_cond, lvl_evt, sel_chg;
  logic          lock_q, lock_d;

  assign sel      = rise_mask_i | fall_mask_i;
  assign edge_hit = (rise_mask_i & cur_i & ~prev_i) |
                    (fall_mask_i & ~cur_i & prev_i);
  assign lvl_ok   = (~rise_mask_i | cur_i) & (~fall_mask_i | ~cur_i);
  assign edge_evt = |edge_hit;
  assign lvl_cond = (|sel) && (&lvl_ok);
  assign sel_chg  = |(sel & (cur_i ^ prev_i));
  assign lvl_evt  = lvl_cond && !lock_q;

  always_comb begin
    evt_o = 1'b0;
    if (en_i) evt_o = (mode_i == CMB_ALL) ? lvl_evt : edge_evt;
  end

  always_comb begin
    lock_d = lock_q;
    if (!en_i || mode_i != CMB_ALL) lock_d = 1'b0;
    else if (lvl_evt)               lock_d = 1'b1;
    else if (sel_chg)               lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  // R10
  no_evt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !evt_o);

  // R4
  evt_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (|sel));

  // R6
  lvl_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_o) && $past(en_i) && $past(mode_i == CMB_ALL) &&
     en_i && mode_i == CMB_ALL) |-> !evt_o);

endmodule

// File: rtl/cos_irq_unit.sv
module cos_irq_unit
  import cos_pkg::*;
#(
  parameter int unsigned NUM_IN   = 32,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned AW       = BUS_AW,
  parameter int unsigned DW       = BUS_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NUM_IN-1:0] din,
  output logic          irq_o
);

  logic                rst_meta_q, rst_sync_q;
  logic [NUM_IN-1:0]   in_cur, in_prev;
  logic [DW-1:0]       rise_mask, fall_mask;
  combine_e            mode;
  logic                en, stat_rd, evt;
  logic                pend_q, pend_d;
  logic [NUM_IRQ-1:0]  snap_q, snap_d;
  logic [DW-1:0]       raw_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cos_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_LEN)) sync_i (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (din),
    .sync_o  (in_cur),
    .prev_o  (in_prev)
  );

  always_comb begin
    raw_word = '0;
    raw_word[NUM_IN-1:0] = in_cur;
  end

  cos_regs #(.DW(DW), .AW(AW), .SNAP_W(NUM_IRQ)) regs_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .wr_i        (bus_wr),
    .rd_i        (bus_rd),
    .addr_i      (bus_addr),
    .wdata_i     (bus_wdata),
    .raw_i       (raw_word),
    .snap_i      (snap_q),
    .rdata_o     (bus_rdata),
    .rise_mask_o (rise_mask),
    .fall_mask_o (fall_mask),
    .mode_o      (mode),
    .en_o        (en),
    .stat_rd_o   (stat_rd)
  );

  cos_detect #(.CH(NUM_IRQ)) det_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cur_i       (in_cur[NUM_IRQ-1:0]),
    .prev_i      (in_prev[NUM_IRQ-1:0]),
    .rise_mask_i (rise_mask[NUM_IRQ-1:0]),
    .fall_mask_i (fall_mask[NUM_IRQ-1:0]),
    .mode_i      (mode),
    .en_i        (en),
    .evt_o       (evt)
  );

  always_comb begin
    pend_d = pend_q;
    snap_d = snap_q;
    if (evt && (!pend_q || stat_rd)) begin
      pend_d = 1'b1;
      snap_d = in_cur[NUM_IRQ-1:0];
    end else if (stat_rd) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      pend_q <= 1'b0;
      snap_q <= '0;
    end else begin
      pend_q <= pend_d;
      snap_q <= snap_d;
    end
  end

  assign irq_o = pend_q && en;

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (stat_rd && !evt) |=> !pend_q);

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pend_q && !stat_rd) |=> $stable(snap_q));

  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pend_q && !stat_rd) |=> pend_q);

endmodule

// File: tb/cos_irq_unit_tb.sv
module cos_irq_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] din = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cos_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(din), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_in(input logic [31:0] v);
    @(negedge clk);
    din = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string req);
    check(irq_o === e, req, {31'b0, irq_o}, {31'b0, e});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(5'h04, d); check(d === 0, "R11 rise mask", d, 0);
    rd(5'h08, d); check(d === 0, "R11 fall mask", d, 0);
    rd(5'h10, d); check(d === 0, "R11 ctrl", d, 0);
    expect_irq(1'b0, "R11 irq");

    // R1 walking ones and mixed patterns on raw register
    for (int i = 0; i < 32; i++) begin
      set_in(32'h1 << i);
      rd(5'h00, d); check(d === (32'h1 << i), "R1 raw walk", d, 32'h1 << i);
    end
    set_in(32'hA5C3_0F96);
    rd(5'h00, d); check(d === 32'hA5C3_0F96, "R1 raw pattern", d, 32'hA5C3_0F96);
    set_in(32'h0);

    // R2 readback
    wr(5'h04, 32'hDEAD_BEEF); rd(5'h04, d); check(d === 32'hDEAD_BEEF, "R2 rise", d, 32'hDEAD_BEEF);
    wr(5'h08, 32'h1234_5678); rd(5'h08, d); check(d === 32'h1234_5678, "R2 fall", d, 32'h1234_5678);
    for (int v = 0; v < 8; v++) begin
      wr(5'h10, 32'hFFFF_FFF8 | v);
      rd(5'h10, d); check(d === (v & 6), "R2 ctrl", d, v & 6);
    end
    wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
    rd(5'h0C, d);

    // R3 edge polarity sweep over all interruptible channels
    for (int c = 0; c < 16; c++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic [31:0] base, tog;
        base = (dir == 0) ? 32'h0 : 32'hFFFF_FFFF;
        tog  = base ^ (32'h1 << c);
        set_in(base);
        wr(5'h04, dir == 0 ? (32'h1 << c) : 0);
        wr(5'h08, dir == 1 ? (32'h1 << c) : 0);
        wr(5'h10, 32'h4);
        set_in(tog);
        expect_irq(1'b1, "R3 armed edge");
        rd(5'h0C, d); check(d === {16'h0, tog[15:0]}, "R7 edge snapshot", d, {16'h0, tog[15:0]});
        @(negedge clk); expect_irq(1'b0, "R7 cleared");
        set_in(base);
        expect_irq(1'b0, "R3 opposite edge");
        // R4 other channel toggles are ignored
        set_in(base ^ (32'h1 << ((c + 1) % 16)));
        expect_irq(1'b0, "R4 unselected channel");
        wr(5'h10, 0);
      end
    end

    // R4 upper mask bits never fire
    set_in(0);
    wr(5'h04, 32'hFFFF_0000); wr(5'h08, 32'hFFFF_0000); wr(5'h10, 32'h4);
    set_in(32'hFFFF_0000); expect_irq(1'b0, "R4 upper rise");
    set_in(32'h0);         expect_irq(1'b0, "R4 upper fall");

    // R5 / R6 level sweep: ch0, ch1 high and ch2 low
    wr(5'h10, 0);
    wr(5'h04, 32'h0003_0003); wr(5'h08, 32'h4);
    set_in(32'h4);
    wr(5'h10, 32'h6);
    for (int v = 0; v < 8; v++) begin
      set_in(32'h4);
      rd(5'h0C, d);
      set_in(v);
      expect_irq(v == 3, "R5 level all-match");
      if (v == 3) begin
        rd(5'h0C, d); check(d === 32'h3, "R7 level snapshot", d, 32'h3);
        repeat (6) @(negedge clk);
        expect_irq(1'b0, "R6 locked while steady");
        set_in(32'h2); expect_irq(1'b0, "R6 release step");
        set_in(32'h3); expect_irq(1'b1, "R6 refire after change");
        rd(5'h0C, d);
      end
    end

    // R8 enable gating keeps the pending event
    wr(5'h10, 0);
    set_in(0);
    wr(5'h04, 32'h1); wr(5'h08, 0); wr(5'h10, 32'h4);
    set_in(32'h1); expect_irq(1'b1, "R8 fired");
    wr(5'h10, 32'h0); expect_irq(1'b0, "R8 gated off");
    wr(5'h10, 32'h4); expect_irq(1'b1, "R8 re-asserted");
    rd(5'h0C, d); check(d === 32'h1, "R8 snapshot kept", d, 32'h1);

    // R9 second event keeps first snapshot
    set_in(0);
    wr(5'h04, 32'h3);
    rd(5'h0C, d);
    set_in(32'h1); expect_irq(1'b1, "R9 first");
    set_in(32'h3);
    rd(5'h0C, d); check(d === 32'h1, "R9 snapshot held", d, 32'h1);
    @(negedge clk); expect_irq(1'b0, "R9 cleared");

    // R10 disabled: no event is recorded
    wr(5'h10, 32'h0);
    set_in(0); set_in(32'h3);
    wr(5'h10, 32'h4); expect_irq(1'b0, "R10 nothing pending");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule